// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is one counter channel of a three-channel interval timer that sits on an 8-bit host bus. The host programs it with a control word at address 3. The control word picks how count bytes are transferred, which of six counting modes runs, and whether the count runs in binary or four-digit BCD. The host then writes the initial count at the channel's own address. The count is first held in a staging register and reaches the 16-bit down counter only on a later counter-clock tick. Counting advances on a counter-clock enable that is sampled in the system clock domain, and a gate input either pauses counting or triggers it, depending on the mode. The single output pin gives interrupts, one-shot pulses, rate pulses, square waves or strobes.

The host can freeze the live count in an output latch with a latch command. It can also freeze a status byte (output level, a pending-load flag and the programmed setup) with a read-back command. Later reads return the frozen values in a fixed order. All three channels share the control-word decode format, so one bus write can address several channels.

Top module: `pit_channel`

## Requirements
- R1: A write to address 3 is a control word. Bits [7:6] select the channel, and only the value CH_ID (default 0) affects this channel; 3 means read-back. Bits [5:4] set access: 01 low byte only, 10 high byte only, 11 low then high, 00 latch command. Bits [3:1] set the mode, with 6 and 7 acting as modes 2 and 3. Bit 0 selects BCD. After a new control word the output is low for mode 0 and high for every other mode.
- R2: A completed count write goes into a staging register. The counter keeps its old value until the next counter-clock tick loads it (modes 0, 2, 3 and 4 when idle). Status bit 6 reads 1 while a written count waits to be loaded and 0 after the load.
- R3: Mode 0: the output stays low after the load and rises on the tick that brings the count from 1 to 0. It then stays high while the counter wraps. A low gate holds the count.
- R4: Mode 1: a rising gate edge loads the count on the next tick and drives the output low. The output goes high after N further ticks. A new rising edge retriggers the sequence.
- R5: Mode 2: the output goes low for one tick when the count reaches 1, and the count then reloads automatically. A low gate halts counting and forces the output high on the next tick.
- R6: Mode 3: a square wave with the output high for ceil(N/2) ticks and low for floor(N/2) ticks, reloading from the staging register at each half.
- R7: Mode 4: the tick that takes the count from 1 to 0 drives the output low for exactly one tick. Only one strobe comes per loaded count.
- R8: Mode 5: as mode 4, but the load is started by a rising gate edge instead of the count write.
- R9: In BCD mode the counter decrements by decimal digits, and 0000 wraps to 9999.
- R10: A latch command (access 00 for this channel, or read-back with bit 5 = 0 and this channel's select bit [CH_ID+1] = 1) freezes the count. Reads return the frozen value until it has been fully read. Further latch commands are ignored until then.
- R11: Read-back with bit 4 = 0 freezes the status byte {out level, pending-load flag, access[1:0], mode[2:0], BCD}. When both count and status are latched, status is read first.
- R12: In low-then-high access, count writes and reads each alternate between low and high byte. A new control word resets both to low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single-cycle host write strobe |
| rd_en | input | 1 | Single-cycle host read strobe |
| addr | input | 2 | Register address: channel number or 3 for control |
| din | input | 8 | Host write data |
| dout | output | 8 | Read data, valid while rd_en selects this channel, else 0 |
| cnt_clk_en | input | 1 | Counter clock, sampled as an enable on clk |
| gate | input | 1 | Gate level, sampled on clk |
| out_pin | output | 1 | Counter output |

## Verification
The bench reads the live counter between the count write and the loading tick. A design that loads on the write would return the new count instead of the reset value. The odd square-wave count is traced tick by tick, so a design that splits the period evenly, or gives the extra tick to the low half, shows a wrong sequence. A repeated latch command between count changes and a control word issued halfway through a two-byte write both catch designs that relatch or keep a stale byte pointer. A control word aimed at another channel, and a combined read-back returning status before count, expose loose select decoding and wrong read order.

// File: rtl/pit_pkg.sv
`timescale 1ns/1ps
package pit_pkg;
  typedef enum logic [2:0] {
    M_TCINT   = 3'd0,
    M_ONESHOT = 3'd1,
    M_RATE    = 3'd2,
    M_SQUARE  = 3'd3,
    M_SWSTB   = 3'd4,
    M_HWSTB   = 3'd5
  } pit_mode_e;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'd0,
    ACC_LO    = 2'd1,
    ACC_HI    = 2'd2,
    ACC_LOHI  = 2'd3
  } pit_acc_e;
endpackage

// File: rtl/pit_dec1.sv
`timescale 1ns/1ps
// Subtract one from the counter value, either binary or digit-wise BCD.
module pit_dec1 #(
  parameter int W = 16
) (
  input  logic [W-1:0] val,
  input  logic         bcd,
  output logic [W-1:0] res
);
  localparam int NDIG = W / 4;

  logic [NDIG:0]  borrow;
  logic [W-1:0]   bcd_res;

  assign borrow[0] = 1'b1;

  for (genvar g = 0; g < NDIG; g++) begin : g_digit
    logic [3:0] dig;
    assign dig = val[4*g +: 4];
    assign bcd_res[4*g +: 4] = !borrow[g] ? dig :
                               (dig == 4'd0) ? 4'd9 : dig - 4'd1;
    assign borrow[g+1] = borrow[g] & (dig == 4'd0);
  end

  assign res = bcd ? bcd_res : val - W'(1);
endmodule

// File: rtl/pit_readout.sv
`timescale 1ns/1ps
// Count and status latches plus the read-data multiplexer.
module pit_readout
  import pit_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         rd,
  input  logic         lat_cnt,
  input  logic         lat_st,
  input  pit_acc_e     acc,
  input  logic [W-1:0] ce,
  input  logic [7:0]   status,
  output logic [7:0]   dout,
  output logic         ol_valid,
  output logic [W-1:0] ol_val
);
  logic [W-1:0] ol_q, ol_d;
  logic         olv_q, olv_d;
  logic [7:0]   st_q, st_d;
  logic         stv_q, stv_d;
  logic         hi_q, hi_d;
  logic [W-1:0] src;
  logic         use_hi;

  always_comb begin
    ol_d  = ol_q;
    olv_d = olv_q;
    st_d  = st_q;
    stv_d = stv_q;
    hi_d  = hi_q;
    if (clr) begin
      olv_d = 1'b0;
      stv_d = 1'b0;
      hi_d  = 1'b0;
    end else begin
      if (rd) begin
        if (stv_q) begin
          stv_d = 1'b0;
        end else begin
          if (acc == ACC_LOHI) hi_d = ~hi_q;
          if (olv_q && (acc != ACC_LOHI || hi_q)) olv_d = 1'b0;
        end
      end
      if (lat_cnt && !olv_q) begin
        ol_d  = ce;
        olv_d = 1'b1;
      end
      if (lat_st && !stv_q) begin
        st_d  = status;
        stv_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ol_q  <= '0;
      olv_q <= 1'b0;
      st_q  <= '0;
      stv_q <= 1'b0;
      hi_q  <= 1'b0;
    end else begin
      ol_q  <= ol_d;
      olv_q <= olv_d;
      st_q  <= st_d;
      stv_q <= stv_d;
      hi_q  <= hi_d;
    end
  end

  assign src    = olv_q ? ol_q : ce;
  assign use_hi = (acc == ACC_HI) || (acc == ACC_LOHI && hi_q);
  assign dout   = !rd ? 8'h00 : stv_q ? st_q : use_hi ? src[W-1:8] : src[7:0];

  assign ol_valid = olv_q;
  assign ol_val   = ol_q;
endmodule

// File: rtl/pit_channel.sv
`timescale 1ns/1ps
module pit_channel
  import pit_pkg::*;
#(
  parameter int CH_ID = 0,
  parameter int W     = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [1:0] addr,
  input  logic [7:0] din,
  output logic [7:0] dout,
  input  logic       cnt_clk_en,
  input  logic       gate,
  output logic       out_pin
);
  localparam logic [1:0] CH_SEL = 2'(CH_ID);

  pit_mode_e    mode_q, mode_d;
  pit_acc_e     acc_q, acc_d;
  logic         bcd_q, bcd_d;
  logic [W-1:0] cr_q, cr_d, ce_q, ce_d;
  logic         wr_hi_q, wr_hi_d, out_q, out_d, run_q, run_d;
  logic         pend_q, pend_d, trig_q, trig_d, have_q, have_d;
  logic         null_q, null_d, extra_q, extra_d, armed_q, armed_d, gate_q;

  logic         cw_hit, rb_cmd, mine, new_cw, lat_cnt, lat_st, data_wr, data_rd;
  logic [W-1:0] dec1, dec2;
  logic [7:0]   status;
  logic         ol_valid;
  logic [W-1:0] ol_val;

  assign cw_hit  = wr_en && addr == 2'b11;
  assign rb_cmd  = cw_hit && din[7:6] == 2'b11;
  assign mine    = cw_hit && din[7:6] == CH_SEL;
  assign new_cw  = mine && din[5:4] != 2'b00;
  assign lat_cnt = (mine && din[5:4] == 2'b00) || (rb_cmd && din[CH_ID+1] && !din[5]);
  assign lat_st  = rb_cmd && din[CH_ID+1] && !din[4];
  assign data_wr = wr_en && addr == CH_SEL;
  assign data_rd = rd_en && addr == CH_SEL;
  assign status  = {out_q, null_q, acc_q, mode_q, bcd_q};

  pit_dec1 #(.W(W)) u_dec_a (.val(ce_q), .bcd(bcd_q), .res(dec1));
  pit_dec1 #(.W(W)) u_dec_b (.val(dec1), .bcd(bcd_q), .res(dec2));

  always_comb begin
    logic done, ld, pass, trigd, idle_ld;
    mode_d = mode_q;  acc_d = acc_q;    bcd_d = bcd_q;
    cr_d = cr_q;      ce_d = ce_q;      wr_hi_d = wr_hi_q;
    out_d = out_q;    run_d = run_q;    pend_d = pend_q;
    trig_d = trig_q;  have_d = have_q;  null_d = null_q;
    extra_d = extra_q; armed_d = armed_q;
    done    = 1'b0;
    trigd   = (mode_q == M_ONESHOT) || (mode_q == M_HWSTB);
    idle_ld = (mode_q == M_TCINT) || (mode_q == M_SWSTB);
    pass    = trigd || gate;
    if (gate && !gate_q) trig_d = 1'b1;
    // count register writes
    if (data_wr) begin
      case (acc_q)
        ACC_LO: begin cr_d = {8'h00, din}; done = 1'b1; end
        ACC_HI: begin cr_d = {din, 8'h00}; done = 1'b1; end
        ACC_LOHI: begin
          if (!wr_hi_q) cr_d[7:0] = din;
          else begin cr_d[W-1:8] = din; done = 1'b1; end
          wr_hi_d = ~wr_hi_q;
        end
        default: ;
      endcase
    end
    if (done) begin
      have_d = 1'b1;
      null_d = 1'b1;
      if (idle_ld || (!trigd && !run_q)) pend_d = 1'b1;
    end
    // counter-clock tick
    if (cnt_clk_en) begin
      ld = trigd ? (trig_q && have_q) : pend_q;
      if (ld) begin
        ce_d    = (mode_q == M_SQUARE) ? {cr_q[W-1:1], 1'b0} : cr_q;
        extra_d = (mode_q == M_SQUARE) && cr_q[0];
        run_d   = 1'b1;  pend_d = 1'b0;  trig_d = 1'b0;
        null_d  = 1'b0;  armed_d = 1'b1;
        out_d   = !(mode_q == M_TCINT || mode_q == M_ONESHOT);
      end else if ((mode_q == M_RATE || mode_q == M_SQUARE) && !gate) begin
        out_d = 1'b1;
      end else if (run_q && pass) begin
        case (mode_q)
          M_TCINT, M_ONESHOT: begin
            ce_d = dec1;
            if (ce_q == W'(1)) out_d = 1'b1;
          end
          M_SWSTB, M_HWSTB: begin
            ce_d = dec1;
            if (!out_q) out_d = 1'b1;
            if (ce_q == W'(1) && armed_q) begin out_d = 1'b0; armed_d = 1'b0; end
          end
          M_RATE: begin
            if (ce_q == W'(1)) begin
              ce_d = cr_q; out_d = 1'b1; null_d = 1'b0;
            end else begin
              ce_d = dec1;
              if (ce_q == W'(2)) out_d = 1'b0;
            end
          end
          M_SQUARE: begin
            if (extra_q) extra_d = 1'b0;
            else if (ce_q == W'(2)) begin
              out_d   = ~out_q;
              ce_d    = {cr_q[W-1:1], 1'b0};
              extra_d = cr_q[0] && !out_q;
              null_d  = 1'b0;
            end else ce_d = dec2;
          end
          default: ;
        endcase
      end
    end
    // a new control word overrides everything else
    if (new_cw) begin
      mode_d  = pit_mode_e'((din[3] && din[2]) ? {1'b0, din[2:1]} : din[3:1]);
      acc_d   = pit_acc_e'(din[5:4]);
      bcd_d   = din[0];
      out_d   = (din[3:1] != 3'd0);
      wr_hi_d = 1'b0;  run_d = 1'b0;  pend_d = 1'b0;  trig_d = 1'b0;
      have_d  = 1'b0;  null_d = 1'b1; extra_d = 1'b0; armed_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_TCINT;  acc_q <= ACC_LATCH;  bcd_q <= 1'b0;
      cr_q <= '0;  ce_q <= '0;  wr_hi_q <= 1'b0;  out_q <= 1'b0;
      run_q <= 1'b0;  pend_q <= 1'b0;  trig_q <= 1'b0;  have_q <= 1'b0;
      null_q <= 1'b0;  extra_q <= 1'b0;  armed_q <= 1'b0;  gate_q <= 1'b0;
    end else begin
      mode_q <= mode_d;  acc_q <= acc_d;  bcd_q <= bcd_d;
      cr_q <= cr_d;  ce_q <= ce_d;  wr_hi_q <= wr_hi_d;  out_q <= out_d;
      run_q <= run_d;  pend_q <= pend_d;  trig_q <= trig_d;  have_q <= have_d;
      null_q <= null_d;  extra_q <= extra_d;  armed_q <= armed_d;  gate_q <= gate;
    end
  end

  pit_readout #(.W(W)) u_readout (
    .clk(clk), .rst_n(rst_n), .clr(new_cw), .rd(data_rd),
    .lat_cnt(lat_cnt), .lat_st(lat_st), .acc(acc_q), .ce(ce_q),
    .status(status), .dout(dout), .ol_valid(ol_valid), .ol_val(ol_val)
  );

  assign out_pin = out_q;
endmodule

// File: rtl/pit_channel_chk.sv
`timescale 1ns/1ps
module pit_channel_chk #(
  parameter int CH_ID = 0,
  parameter int W     = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic         rd_en,
  input logic [1:0]   addr,
  input logic [7:0]   din,
  input logic         cnt_clk_en,
  input logic         gate,
  input logic         out_pin,
  input logic [2:0]   mode,
  input logic         ol_valid,
  input logic [W-1:0] ol_val
);
  logic cw_w, own_rd, prog_m0;
  assign cw_w    = wr_en && addr == 2'b11;
  assign own_rd  = rd_en && addr == 2'(CH_ID);
  assign prog_m0 = cw_w && din[7:6] == 2'(CH_ID) && din[5:4] != 2'b00 && din[3:1] == 3'd0;

  // R1
  mode0_prog_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_m0 |=> !out_pin);

  // R5
  rate_gate_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 3'd2 || mode == 3'd3) && !gate && cnt_clk_en && !cw_w) |=> out_pin);

  // R7
  strobe_one_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 3'd4 || mode == 3'd5) && !out_pin && cnt_clk_en && !cw_w) |=> out_pin);

  // R10
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ol_valid && !own_rd && !cw_w) |=> (ol_valid && $stable(ol_val)));

  // R3
  out_only_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_clk_en && !cw_w) |=> $stable(out_pin));
endmodule

bind pit_channel pit_channel_chk #(.CH_ID(CH_ID), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .din(din), .cnt_clk_en(cnt_clk_en), .gate(gate), .out_pin(out_pin),
  .mode(mode_q), .ol_valid(ol_valid), .ol_val(ol_val)
);

// File: tb/tb_pit_channel.sv
`timescale 1ns/1ps
module tb_pit_channel;
  logic       clk = 1'b0;
  logic       rst_n, wr_en, rd_en, cnt_clk_en, gate, out_pin;
  logic [1:0] addr;
  logic [7:0] din, dout;
  int         errs = 0;
  int         checks = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  pit_channel dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .din(din), .dout(dout), .cnt_clk_en(cnt_clk_en), .gate(gate), .out_pin(out_pin)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compares each read byte against the queued expectation
  always @(negedge clk) begin
    if (rd_en) begin
      if (exp_q.size() == 0) check(dout, 8'hxx, "unexpected read");
      else check(dout, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1 wr_en = 1'b1; addr = a; din = d;
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(posedge clk); #1 rd_en = 1'b1; addr = 2'd0;
    @(posedge clk); #1 rd_en = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 cnt_clk_en = 1'b1;
      @(posedge clk); #1 cnt_clk_en = 1'b0;
    end
  endtask

  task automatic set_gate(input logic v);
    @(posedge clk); #1 gate = v;
    @(posedge clk); #1;
  endtask

  task automatic chk_out(input logic exp, input string tag);
    @(negedge clk);
    check({7'd0, out_pin}, {7'd0, exp}, tag);
  endtask

  initial begin
    #(8 * 200000);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic sq_exp [8] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0};
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = 2'd0; din = 8'h00;
    cnt_clk_en = 1'b0; gate = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk_out(1'b0, "reset out");
    @(negedge clk); check(dout, 8'h00, "reset dout idle");

    // R1 R3 R2: mode 0, low-then-high binary
    wr(2'd3, 8'h30);
    chk_out(1'b0, "R1 mode0 out low");
    wr(2'd0, 8'h05); wr(2'd0, 8'h00);
    wr(2'd3, 8'hE2);
    rd(8'h70, "R2 status null count set");
    rd(8'h00, "R2 counter not yet loaded lo");
    rd(8'h00, "R2 counter not yet loaded hi");
    tick(1);
    tick(2);
    rd(8'h05, "R3 gate low holds lo");
    rd(8'h00, "R3 gate low holds hi");
    wr(2'd3, 8'hE2);
    rd(8'h30, "R2 status null cleared after load");
    set_gate(1'b1);
    tick(4);
    chk_out(1'b0, "R3 out low before zero");
    tick(1);
    chk_out(1'b1, "R3 out high at zero");

    // R10 latch and repeated latch ignored
    wr(2'd3, 8'h00);
    tick(3);
    wr(2'd3, 8'h00);
    rd(8'h00, "R10 latched lo");
    rd(8'h00, "R10 latched hi");
    rd(8'hFD, "R10 live lo after latch read");
    rd(8'hFF, "R10 live hi after latch read");
    chk_out(1'b1, "R3 out stays high after wrap");

    // R9 BCD
    wr(2'd3, 8'h31);
    wr(2'd0, 8'h01); wr(2'd0, 8'h00);
    tick(2);
    chk_out(1'b1, "R9 bcd zero reached");
    tick(1);
    rd(8'h99, "R9 bcd wrap lo");
    rd(8'h99, "R9 bcd wrap hi");

    // R5 rate generator via mode code 6
    wr(2'd3, 8'h3C);
    chk_out(1'b1, "R1 mode6 out high");
    wr(2'd0, 8'h03); wr(2'd0, 8'h00);
    tick(3);
    chk_out(1'b0, "R5 pulse low");
    tick(1);
    chk_out(1'b1, "R5 reload high");
    tick(2);
    chk_out(1'b0, "R5 second pulse low");
    wr(2'd3, 8'hE2);
    rd(8'h34, "R1 mode6 aliased to 2 in status");
    set_gate(1'b0);
    tick(1);
    chk_out(1'b1, "R5 gate low forces high");

    // R6 square wave odd count 5, low byte only
    wr(2'd3, 8'h16);
    wr(2'd0, 8'h05);
    set_gate(1'b1);
    tick(1);
    for (int i = 0; i < 8; i++) begin
      tick(1);
      chk_out(sq_exp[i], $sformatf("R6 square tick %0d", i + 1));
    end

    // R7 software strobe
    wr(2'd3, 8'h18);
    wr(2'd0, 8'h02);
    tick(2);
    chk_out(1'b1, "R7 before strobe");
    tick(1);
    chk_out(1'b0, "R7 strobe low");
    tick(1);
    chk_out(1'b1, "R7 strobe one tick");
    tick(3);
    chk_out(1'b1, "R7 single strobe only");

    // R4 one-shot
    wr(2'd3, 8'h12);
    wr(2'd0, 8'h03);
    set_gate(1'b0);
    tick(2);
    chk_out(1'b1, "R4 no trigger stays high");
    set_gate(1'b1);
    tick(1);
    chk_out(1'b0, "R4 triggered low");
    tick(2);
    chk_out(1'b0, "R4 still low");
    tick(1);
    chk_out(1'b1, "R4 end of shot");
    set_gate(1'b0); set_gate(1'b1);
    tick(1);
    chk_out(1'b0, "R4 retrigger low");

    // R8 hardware strobe
    wr(2'd3, 8'h1A);
    wr(2'd0, 8'h01);
    set_gate(1'b0); set_gate(1'b1);
    tick(1);
    chk_out(1'b1, "R8 loaded high");
    tick(1);
    chk_out(1'b0, "R8 strobe low");
    tick(1);
    chk_out(1'b1, "R8 strobe one tick");

    // R12 byte pointer reset, R1 select, R11 status before count
    wr(2'd3, 8'h30);
    wr(2'd0, 8'h12);
    wr(2'd3, 8'h30);
    wr(2'd0, 8'h34); wr(2'd0, 8'h00);
    set_gate(1'b0);
    tick(1);
    wr(2'd3, 8'h52);
    chk_out(1'b0, "R1 other channel word ignored");
    wr(2'd3, 8'hC2);
    rd(8'h30, "R11 status first");
    rd(8'h34, "R12 count lo after pointer reset");
    rd(8'h00, "R12 count hi");

    repeat (4) @(posedge clk);
    check(8'(exp_q.size()), 8'd0, "scoreboard drained");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule